// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block turns single-word read and write requests from an internal valid/ready port into pin-level cycles on an external asynchronous 8K x 8 static RAM. The RAM is selected through two enables of opposite sense: one is low-true and the other is high-true. It also has a low-true write strobe, a low-true output enable and one shared 8-bit data bus. The bus is brought out as a separate drive value, a separate sample value and a tristate enable, so that the pad ring can build the bidirectional pin.

Every RAM timing interval is a parameter counted in clock cycles. These are the read access time, the write strobe width, the minimum spacing between accesses, and the time the RAM outputs need to release. This lets one netlist meet any speed grade at any clock rate. Every RAM control output comes straight from a flop and changes only on a clock edge. While no request is in progress, the RAM is deselected and the bus is released, so the part sits in low-current standby.

The state machine has five states:
- `ST_IDLE`: ready, RAM deselected.
- `ST_RD_ACCESS`: selected, output enable low, waiting out the access time.
- `ST_WR_TURN`: selected, strobe high, bus undriven.
- `ST_WR_STROBE`: strobe low, data driven.
- `ST_RECOVER`: deselected, padding out the access spacing.

The transitions are:
- IDLE to RD_ACCESS when a read is accepted.
- IDLE to WR_TURN when a write is accepted and the previous access was a read.
- IDLE to WR_STROBE when a write is accepted and there was no previous read.
- RD_ACCESS to RECOVER once the access count expires, with data capture on that edge.
- WR_TURN to WR_STROBE once the release count expires.
- WR_STROBE to RECOVER once the strobe count expires.
- RECOVER to IDLE once the recovery count expires.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, the RAM is deselected (`ram_en1_n`=1, `ram_en2`=0), `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0 and `req_ready`=1.
- R2: The two enables always move together: `ram_en1_n` equals the inverse of `ram_en2` in every cycle. The RAM counts as selected only when `ram_en1_n`=0 and `ram_en2`=1.
- R3: An accepted read selects the RAM with `ram_addr` = request address, `ram_oe_n`=0 and `ram_we_n`=1 for exactly `T_ACC` cycles. `ram_dq_in` is sampled on the edge that ends this window and never earlier.
- R4: A read returns the sampled byte on `rsp_rdata` with `rsp_valid` high for exactly one cycle. A write never raises `rsp_valid`.
- R5: A write holds `ram_we_n` low for exactly `T_WP` cycles. It drives `ram_dq_out` = write data with `ram_dq_oe`=1 over exactly those cycles, and it ends strobe, drive and select on the same edge.
- R6: `ram_oe_n` stays high for the whole of every write, and `ram_dq_oe` is never high while `ram_oe_n` is low.
- R7: A write whose previous access was a read first holds the RAM selected, with strobe high and bus undriven, for `T_OZ` cycles. A write that follows a write, or the first access after reset, drives from its first selected cycle.
- R8: `req_ready` is low from the accepting edge until the controller is idle again. Successive select starts are at least `T_CYC` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| ram_addr | output | 13 | RAM address pins |
| ram_en1_n | output | 1 | RAM enable, low-true |
| ram_en2 | output | 1 | RAM enable, high-true |
| ram_we_n | output | 1 | RAM write strobe, low-true |
| ram_oe_n | output | 1 | RAM output enable, low-true |
| ram_dq_out | output | 8 | Value driven onto the data pins |
| ram_dq_oe | output | 1 | Tristate enable for the data pins |
| ram_dq_in | input | 8 | Value sampled from the data pins |

## Verification
The bench's RAM model presents a poison byte until the configured access count has elapsed. A controller that captures one edge early therefore returns the poison instead of the stored byte. A write issued straight after a read is timed for its drive delay against a write issued after a write. If the release guard is missing, the bus is driven on the first selected cycle. If the guard is applied in every case, back-to-back writes become too long. The bench measures strobe width, select duration, output-enable level during writes, response pulse width and the spacing between select starts. It uses the address extremes 0 and 8191 so that truncated addressing reads back the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_TURN,
        ST_WR_STROBE,
        ST_RECOVER
    } ctrl_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Recovery cycles so that select starts are at least cyc apart,
    // given an active phase of act cycles and one idle cycle; never below 1.
    function automatic int rec_len(input int cyc, input int act);
        return (cyc > act + 1) ? (cyc - act - 1) : 1;
    endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int T_ACC = 3,
    parameter int T_WP  = 2,
    parameter int T_CYC = 6,
    parameter int T_OZ  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    output ctrl_state_t state_o,
    output ctrl_state_t nxt_o,
    output logic        accept_o,
    output logic        capture_o
);

    localparam int REC_RD = rec_len(T_CYC, T_ACC);
    localparam int REC_WR = rec_len(T_CYC, T_WP);
    localparam int MAXV   = max2(max2(T_ACC, T_WP), max2(max2(T_OZ, REC_RD), REC_WR));
    localparam int CW     = $clog2(MAXV + 1) + 1;

    ctrl_state_t    state, nxt;
    logic [CW-1:0]  cnt, cnt_nxt;
    logic           last_rd;
    logic           accept;

    assign accept    = req_valid && (state == ST_IDLE);
    assign accept_o  = accept;
    assign capture_o = (state == ST_RD_ACCESS) && (cnt == '0);
    assign state_o   = state;
    assign nxt_o     = nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            last_rd <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (accept) begin
                last_rd <= !req_write;
            end
        end
    end

    // next state and interval counter
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        nxt     = ST_RD_ACCESS;
                        cnt_nxt = CW'(T_ACC - 1);
                    end else if (last_rd) begin
                        nxt     = ST_WR_TURN;
                        cnt_nxt = CW'(T_OZ - 1);
                    end else begin
                        nxt     = ST_WR_STROBE;
                        cnt_nxt = CW'(T_WP - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (cnt == '0) begin
                    nxt     = ST_RECOVER;
                    cnt_nxt = CW'(REC_RD - 1);
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_WR_TURN: begin
                if (cnt == '0) begin
                    nxt     = ST_WR_STROBE;
                    cnt_nxt = CW'(T_WP - 1);
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_WR_STROBE: begin
                if (cnt == '0) begin
                    nxt     = ST_RECOVER;
                    cnt_nxt = CW'(REC_WR - 1);
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt == '0) begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: begin
                nxt     = ST_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

endmodule

// File: rtl/sram_ctrl_strobes.sv
module sram_ctrl_strobes
    import sram_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctrl_state_t nxt,
    output logic        ram_en1_n,
    output logic        ram_en2,
    output logic        ram_we_n,
    output logic        ram_oe_n,
    output logic        ram_dq_oe
);

    logic sel_d;

    always_comb begin
        sel_d = (nxt == ST_RD_ACCESS) || (nxt == ST_WR_TURN) || (nxt == ST_WR_STROBE);
    end

    // output registers, loaded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_en1_n <= 1'b1;
            ram_en2   <= 1'b0;
            ram_we_n  <= 1'b1;
            ram_oe_n  <= 1'b1;
            ram_dq_oe <= 1'b0;
        end else begin
            ram_en1_n <= !sel_d;
            ram_en2   <= sel_d;
            ram_we_n  <= (nxt != ST_WR_STROBE);
            ram_oe_n  <= (nxt != ST_RD_ACCESS);
            ram_dq_oe <= (nxt == ST_WR_STROBE);
        end
    end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            ram_dq_out <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= capture;
            if (accept) begin
                ram_addr   <= req_addr;
                ram_dq_out <= req_wdata;
            end
            if (capture) begin
                rsp_rdata <= ram_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 3,
    parameter int T_WP   = 2,
    parameter int T_CYC  = 6,
    parameter int T_OZ   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_en1_n,
    output logic              ram_en2,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    ctrl_state_t state, nxt;
    logic        accept, capture;

    assign req_ready = (state == ST_IDLE);

    sram_ctrl_fsm #(
        .T_ACC(T_ACC), .T_WP(T_WP), .T_CYC(T_CYC), .T_OZ(T_OZ)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .state_o(state), .nxt_o(nxt), .accept_o(accept), .capture_o(capture)
    );

    sram_ctrl_strobes u_strobes (
        .clk(clk), .rst_n(rst_n), .nxt(nxt),
        .ram_en1_n(ram_en1_n), .ram_en2(ram_en2), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_oe(ram_dq_oe)
    );

    sram_ctrl_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .ram_dq_in(ram_dq_in),
        .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int T_WP = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic ram_en1_n,
    input logic ram_en2,
    input logic ram_we_n,
    input logic ram_oe_n,
    input logic ram_dq_oe
);

    logic [7:0] wl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_cnt <= '0;
        end else if (!ram_we_n) begin
            wl_cnt <= wl_cnt + 1'b1;
        end else begin
            wl_cnt <= '0;
        end
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_en1_n && !ram_en2 && ram_we_n && ram_oe_n && !ram_dq_oe)); // R1
    AST_ENABLES_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en1_n == !ram_en2); // R2
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (wl_cnt == 8'(T_WP))); // R5
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_en1_n && ram_en2 && ram_dq_oe)); // R5
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n); // R6
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ram_oe_n); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en1_n |-> !req_ready); // R8

endmodule

bind sram_cycle_ctrl sram_ctrl_checker #(.T_WP(T_WP)) u_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .ram_en1_n(ram_en1_n), .ram_en2(ram_en2), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_dq_oe(ram_dq_oe)
);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int T_ACC = 3;
    localparam int T_WP  = 2;
    localparam int T_CYC = 6;
    localparam int T_OZ  = 1;
    localparam int DEPTH = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [12:0] ram_addr;
    logic        ram_en1_n, ram_en2, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  ram_dq_out, ram_dq_in;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int prev_start = -1;

    logic [7:0] mem [DEPTH];
    int         acc_cnt = 0;
    logic       ram_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
        .ram_en1_n(ram_en1_n), .ram_en2(ram_en2), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    // RAM model: data becomes valid only after the full access count
    assign ram_sel   = !ram_en1_n && ram_en2;
    assign ram_dq_in = (ram_sel && !ram_oe_n && ram_we_n && acc_cnt >= T_ACC - 1)
                       ? mem[ram_addr] : 8'hEE;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        acc_cnt <= (ram_sel && !ram_oe_n && ram_we_n) ? acc_cnt + 1 : 0;
        if (ram_sel && !ram_we_n && ram_dq_oe) mem[ram_addr] <= ram_dq_out;
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one access and measure its pin behaviour at negedges.
    task automatic run_access(input bit wr, input logic [12:0] a, input logic [7:0] d,
                              input bit turn, input logic [7:0] exp_rd);
        int sel_n = 0, wl = 0, oel = 0, first_drv = -1, rsp_n = 0;
        int oe_in_wr = 0, contention = 0, addr_bad = 0, data_bad = 0, start;
        logic [7:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        start = cyc;
        check(!req_ready, "R8", "ready after accept", int'(req_ready), 0);
        while (!req_ready) begin
            if (ram_sel) begin
                if (ram_addr != a) addr_bad++;
                if (ram_dq_oe && first_drv < 0) first_drv = sel_n;
                if (ram_dq_oe && ram_dq_out != d) data_bad++;
                sel_n++;
            end
            if (!ram_we_n) wl++;
            if (!ram_oe_n) oel++;
            if (wr && !ram_oe_n) oe_in_wr++;
            if (ram_dq_oe && !ram_oe_n) contention++;
            if (rsp_valid) begin rsp_n++; got = rsp_rdata; end
            @(negedge clk);
        end
        if (rsp_valid) begin rsp_n++; got = rsp_rdata; end
        if (prev_start >= 0)
            check(start - prev_start >= T_CYC, "R8", "select spacing", start - prev_start, T_CYC);
        prev_start = start;
        check(addr_bad == 0, "R3", "address held while selected", addr_bad, 0);
        check(contention == 0, "R6", "drive with output enable low", contention, 0);
        if (!wr) begin
            check(sel_n == T_ACC, "R3", "read select cycles", sel_n, T_ACC);
            check(oel == T_ACC, "R3", "output enable cycles", oel, T_ACC);
            check(wl == 0, "R3", "strobe during read", wl, 0);
            check(rsp_n == 1, "R4", "read response pulses", rsp_n, 1);
            check(got == exp_rd, "R4", "read data", int'(got), int'(exp_rd));
        end else begin
            check(wl == T_WP, "R5", "strobe width", wl, T_WP);
            check(data_bad == 0, "R5", "driven data", data_bad, 0);
            check(rsp_n == 0, "R4", "write response pulses", rsp_n, 0);
            check(oe_in_wr == 0, "R6", "output enable during write", oe_in_wr, 0);
            check(first_drv == (turn ? T_OZ : 0), "R7", "first driven cycle",
                  first_drv, turn ? T_OZ : 0);
            check(sel_n == T_WP + (turn ? T_OZ : 0), "R7", "write select cycles",
                  sel_n, T_WP + (turn ? T_OZ : 0));
        end
        check(ram_en1_n && !ram_en2 && !ram_dq_oe && ram_we_n && ram_oe_n, "R1",
              "standby after access", int'({ram_en1_n, ram_en2, ram_dq_oe}), 4);
    endtask

    task automatic test_reset;
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(ram_en1_n && !ram_en2, "R2", "deselected after reset",
              int'({ram_en1_n, ram_en2}), 2);
        check(ram_we_n && ram_oe_n && !ram_dq_oe, "R1", "strobes after reset",
              int'({ram_we_n, ram_oe_n, ram_dq_oe}), 6);
        check(rsp_valid == 1'b0, "R4", "no response after reset", int'(rsp_valid), 0);
    endtask

    task automatic test_write_chain;   // R5, R7: write after write drives at once
        run_access(1'b1, 13'd0, 8'hA5, 1'b0, 8'h00);
        run_access(1'b1, 13'd8191, 8'h3C, 1'b0, 8'h00);
    endtask

    task automatic test_readback;      // R3, R4: address extremes
        run_access(1'b0, 13'd0, 8'h00, 1'b0, 8'hA5);
        run_access(1'b0, 13'd8191, 8'h00, 1'b0, 8'h3C);
        run_access(1'b0, 13'd4660, 8'h00, 1'b0, 8'(4660 ^ 8'h5A));
    endtask

    task automatic test_turnaround;    // R7: write straight after read
        run_access(1'b1, 13'd100, 8'h81, 1'b1, 8'h00);
        run_access(1'b1, 13'd101, 8'h7E, 1'b0, 8'h00);
        run_access(1'b0, 13'd100, 8'h00, 1'b0, 8'h81);
        run_access(1'b1, 13'd100, 8'h18, 1'b1, 8'h00);
        run_access(1'b0, 13'd100, 8'h00, 1'b0, 8'h18);
        run_access(1'b0, 13'd101, 8'h00, 1'b0, 8'h7E);
    endtask

    task automatic test_idle_gap;      // R1, R2: idle cycles stay in standby
        int bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!(ram_en1_n && !ram_en2 && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready))
                bad++;
        end
        check(bad == 0, "R1", "idle standby cycles", bad, 0);
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            report();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i ^ 8'h5A);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_write_chain();
        test_readback();
        test_idle_gap();
        test_turnaround();
        report();
        $finish;
    end

endmodule